// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This block sits between a 32-bit core and a data memory that is one word wide. It forms the effective address of a load or store from a base register value and a signed 16-bit displacement. It then maps the access onto the four byte lanes of the memory word. Memory is byte addressed. The lane order is big-endian: the byte with the lowest address in a word sits in the most significant bits of the word.

For stores, the block produces byte write enables and a write word with the store value already placed in the right lanes. Word, halfword and byte stores are supported, and a narrow store takes only the low bits of the register. For loads, it takes the word that memory returns, picks out the addressed byte or halfword, and extends it to 32 bits. Each narrow load comes in a signed form and an unsigned form. A word or halfword access at an address that does not suit its size raises a misalignment flag and has no effect on memory. The unit is purely combinational.

Top module: `lsu_be_lanes`

## Requirements
- R1: The effective address is `baseAddr` plus `offsetImm` sign-extended to 32 bits, wrapping modulo 2^32. `memAddr` equals the effective address with bits 1:0 forced to zero, for every operation code.
- R2: `opSel` encodings: 0 idle, 1 load word, 2 load half signed, 3 load half unsigned, 4 load byte signed, 5 load byte unsigned, 6 store word, 7 store half, 8 store byte, and 9 to 15 idle. Bit i of `memByteEn` enables `memWdata`/`memRdata` bits 8i+7:8i. The byte at effective-address offset k (0..3 within the word) lives in bits 31-8k:24-8k, so it uses enable bit 3-k. An aligned word store drives `memByteEn`=4'b1111 and `memWdata`=`storeData`.
- R3: An aligned halfword store places `storeData[15:0]` in both halves of `memWdata`. It drives `memByteEn`=4'b1100 at offset 0 and 4'b0011 at offset 2.
- R4: A byte store places `storeData[7:0]` on all four lanes of `memWdata` and asserts exactly one enable, bit 3-k for offset k. A byte access is never misaligned.
- R5: An aligned word load returns `memRdata` unchanged on `loadResult`.
- R6: A signed halfword load at offset k returns `memRdata` bits 31-8k:16-8k, sign-extended. A signed byte load at offset k returns `memRdata` bits 31-8k:24-8k, sign-extended.
- R7: The unsigned halfword and byte loads select the same bits as in R6 but zero-extend them.
- R8: A word access whose effective-address bits 1:0 are not 00 is misaligned. So is a halfword access whose effective-address bit 0 is 1. A misaligned access sets `misalign`, drives `memByteEn` to 0 and drives `loadResult` to 0.
- R9: Idle codes and all loads drive `memByteEn` to 0. Idle codes and stores drive `loadResult` to 0. Idle codes never set `misalign`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code (see R2) |
| baseAddr | input | 32 | Base register value |
| offsetImm | input | 16 | Signed displacement |
| storeData | input | 32 | Register value to store |
| memRdata | input | 32 | Word returned by memory |
| memAddr | output | 32 | Word-aligned memory address |
| memByteEn | output | 4 | Byte write enables |
| memWdata | output | 32 | Lane-aligned write word |
| loadResult | output | 32 | Extended load value |
| misalign | output | 1 | Access misaligned for its size |

## Verification
The bound checker watches several rules on every input change:
- the memory address always equals the word-cleared effective address;
- a misaligned access leaves the enables and the load result quiet;
- loads and idle codes never enable a lane;
- a byte store always enables exactly one lane, with the byte replicated;
- a halfword store always enables one half;
- a word load passes the memory word straight through.

Which lane a narrow access lands on, and how it is extended, depends on the arithmetic of the effective address. Only the bench's sweep shows this. The sweep covers every code and every low-address residue, with offsets that are negative, that wrap, and that sit at the extremes. Each combination uses read words whose selected bytes have the sign bit set or clear.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,
    OP_LDW  = 4'd1,
    OP_LDH  = 4'd2,
    OP_LDHU = 4'd3,
    OP_LDB  = 4'd4,
    OP_LDBU = 4'd5,
    OP_STW  = 4'd6,
    OP_STH  = 4'd7,
    OP_STB  = 4'd8
  } memOp_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } accSize_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     doLoad;
    logic     doStore;
    accSize_e size;
    logic     signExt;
  } laneCtl_t;

endpackage

// File: rtl/lsu_ctl.sv
module lsu_ctl
  import lsu_pkg::*;
(
  input  logic [3:0] opSel,
  output laneCtl_t   ctl
);

  always_comb begin
    ctl = '{doLoad: 1'b0, doStore: 1'b0, size: SZ_W, signExt: 1'b0};
    case (opSel)
      OP_LDW:  begin ctl.doLoad = 1'b1;  ctl.size = SZ_W; end
      OP_LDH:  begin ctl.doLoad = 1'b1;  ctl.size = SZ_H; ctl.signExt = 1'b1; end
      OP_LDHU: begin ctl.doLoad = 1'b1;  ctl.size = SZ_H; end
      OP_LDB:  begin ctl.doLoad = 1'b1;  ctl.size = SZ_B; ctl.signExt = 1'b1; end
      OP_LDBU: begin ctl.doLoad = 1'b1;  ctl.size = SZ_B; end
      OP_STW:  begin ctl.doStore = 1'b1; ctl.size = SZ_W; end
      OP_STH:  begin ctl.doStore = 1'b1; ctl.size = SZ_H; end
      OP_STB:  begin ctl.doStore = 1'b1; ctl.size = SZ_B; end
      default: ;
    endcase
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  laneCtl_t              ctl,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [OFF_W-1:0]      offsetImm,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LANE_BITS-1:0]  byteOff,
  output logic                  misalign
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] effAddr;
  logic              active;
  logic              halfOdd;
  logic              wordOff;

  assign effAddr = baseAddr + {{EXT_W{offsetImm[OFF_W-1]}}, offsetImm};
  assign byteOff = effAddr[LANE_BITS-1:0];
  assign memAddr = {effAddr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};

  assign active  = ctl.doLoad | ctl.doStore;
  assign halfOdd = effAddr[0];
  assign wordOff = |effAddr[LANE_BITS-1:0];

  always_comb begin
    misalign = 1'b0;
    if (active) begin
      case (ctl.size)
        SZ_W:    misalign = wordOff;
        SZ_H:    misalign = halfOdd;
        default: misalign = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LANES     = DATA_W / 8,
  parameter int LANE_BITS = $clog2(LANES)
) (
  input  laneCtl_t              ctl,
  input  logic [LANE_BITS-1:0]  byteOff,
  input  logic                  misalign,
  input  logic [DATA_W-1:0]     storeData,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [LANES-1:0]      memByteEn,
  output logic [DATA_W-1:0]     memWdata,
  output logic [DATA_W-1:0]     loadResult
);

  localparam int HALVES = LANES / 2;

  logic [7:0]       rdLane [LANES];
  logic [LANES-1:0] laneHit;
  logic [7:0]       rdByte;
  logic [15:0]      rdHalf;
  logic [LANE_BITS-1:0] halfBase;

  assign halfBase = {byteOff[LANE_BITS-1:1], 1'b0};

  // Lane k holds the byte at address offset k (big-endian placement)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * k;

    assign rdLane[k] = memRdata[HI -: 8];

    always_comb begin
      case (ctl.size)
        SZ_W:    laneHit[k] = 1'b1;
        SZ_H:    laneHit[k] = (LANE_BITS'(k) >> 1) == (byteOff >> 1);
        default: laneHit[k] = LANE_BITS'(k) == byteOff;
      endcase
    end

    assign memByteEn[LANES-1-k] = ctl.doStore & ~misalign & laneHit[k];

    if ((k % 2) == 0) begin : g_even
      always_comb begin
        case (ctl.size)
          SZ_W:    memWdata[HI -: 8] = storeData[HI -: 8];
          SZ_H:    memWdata[HI -: 8] = storeData[15:8];
          default: memWdata[HI -: 8] = storeData[7:0];
        endcase
      end
    end else begin : g_odd
      always_comb begin
        case (ctl.size)
          SZ_W:    memWdata[HI -: 8] = storeData[HI -: 8];
          default: memWdata[HI -: 8] = storeData[7:0];
        endcase
      end
    end
  end

  always_comb begin
    rdByte = '0;
    for (int k = 0; k < LANES; k++) begin
      if (LANE_BITS'(k) == byteOff) rdByte = rdLane[k];
    end
  end

  always_comb begin
    rdHalf = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (LANE_BITS'(2 * h) == halfBase) rdHalf = {rdLane[2 * h], rdLane[2 * h + 1]};
    end
  end

  always_comb begin
    loadResult = '0;
    if (ctl.doLoad && !misalign) begin
      case (ctl.size)
        SZ_W: loadResult = memRdata;
        SZ_H: loadResult = {{(DATA_W - 16){ctl.signExt & rdHalf[15]}}, rdHalf};
        default: loadResult = {{(DATA_W - 8){ctl.signExt & rdByte[7]}}, rdByte};
      endcase
    end
  end

endmodule

// File: rtl/lsu_be_lanes.sv
module lsu_be_lanes
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [3:0]        opSel,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offsetImm,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadResult,
  output logic              misalign
);

  laneCtl_t             ctl;
  logic [LANE_BITS-1:0] byteOff;

  lsu_ctl u_ctl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  lsu_agen #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .LANE_BITS (LANE_BITS)
  ) u_agen (
    .ctl       (ctl),
    .baseAddr  (baseAddr),
    .offsetImm (offsetImm),
    .memAddr   (memAddr),
    .byteOff   (byteOff),
    .misalign  (misalign)
  );

  lsu_lanes #(
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .LANE_BITS (LANE_BITS)
  ) u_lanes (
    .ctl        (ctl),
    .byteOff    (byteOff),
    .misalign   (misalign),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .memByteEn  (memByteEn),
    .memWdata   (memWdata),
    .loadResult (loadResult)
  );

endmodule

// File: rtl/lsu_be_lanes_chk.sv
module lsu_be_lanes_chk
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input logic [3:0]        opSel,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [OFF_W-1:0]  offsetImm,
  input logic [DATA_W-1:0] storeData,
  input logic [DATA_W-1:0] memRdata,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  memByteEn,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] loadResult,
  input logic              misalign
);

  logic [ADDR_W-1:0] sumAddr;
  logic isLoadOp, isStoreOp, isByteOp;

  assign sumAddr   = baseAddr + {{(ADDR_W - OFF_W){offsetImm[OFF_W-1]}}, offsetImm};
  assign isLoadOp  = opSel >= 4'd1 && opSel <= 4'd5;
  assign isStoreOp = opSel >= 4'd6 && opSel <= 4'd8;
  assign isByteOp  = opSel == OP_LDB || opSel == OP_LDBU || opSel == OP_STB;

  always_comb begin
    // R1
    word_addr_chk: assert (memAddr == {sumAddr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}});
    // R8
    if (misalign) misalign_quiet_chk: assert (memByteEn == '0 && loadResult == '0);
    // R9
    if (!isStoreOp) no_write_en_chk: assert (memByteEn == '0);
    // R4
    if (isByteOp) byte_never_mis_chk: assert (!misalign);
    // R4
    if (opSel == OP_STB) byte_one_lane_chk: assert ($countones(memByteEn) == 1 &&
                                                    memWdata == {LANES{storeData[7:0]}});
    // R3
    if (opSel == OP_STH && !misalign) half_pair_en_chk: assert (memByteEn == 4'b1100 ||
                                                                 memByteEn == 4'b0011);
    // R5
    if (opSel == OP_LDW && !misalign) word_load_pass_chk: assert (loadResult == memRdata);
  end

endmodule

bind lsu_be_lanes lsu_be_lanes_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W)
) u_chk (.*);

// File: tb/sim_lsu_be_lanes.sv
module sim_lsu_be_lanes;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;

  logic [3:0]  opSel = 4'd0;
  logic [31:0] baseAddr = '0;
  logic [15:0] offsetImm = '0;
  logic [31:0] storeData = '0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr;
  logic [3:0]  memByteEn;
  logic [31:0] memWdata;
  logic [31:0] loadResult;
  logic        misalign;

  always #10 clk = ~clk;

  lsu_be_lanes u0 (
    .opSel      (opSel),
    .baseAddr   (baseAddr),
    .offsetImm  (offsetImm),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memByteEn  (memByteEn),
    .memWdata   (memWdata),
    .loadResult (loadResult),
    .misalign   (misalign)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (op=%0d base=%h off=%h)",
               tag, what, act, exp, opSel, baseAddr, offsetImm);
    end
  endtask

  function automatic string opTag(input logic [3:0] op);
    case (op)
      4'd1:       return "R5";
      4'd2, 4'd4: return "R6";
      4'd3, 4'd5: return "R7";
      4'd6:       return "R2";
      4'd7:       return "R3";
      4'd8:       return "R4";
      default:    return "R9";
    endcase
  endfunction

  task automatic runOne(input logic [3:0] op, input logic [31:0] base,
                        input logic [15:0] off, input logic [31:0] sd,
                        input logic [31:0] rd);
    logic [31:0] ea, expLoad, expWd;
    logic [3:0]  expEn;
    logic [1:0]  lo;
    logic [15:0] hv;
    logic [7:0]  bv;
    logic        isLd, isSt, mis;
    @(negedge clk);
    opSel = op; baseAddr = base; offsetImm = off; storeData = sd; memRdata = rd;
    @(posedge clk);
    #2;
    ea   = base + {{16{off[15]}}, off};
    lo   = ea[1:0];
    isLd = (op >= 4'd1) && (op <= 4'd5);
    isSt = (op >= 4'd6) && (op <= 4'd8);
    mis  = ((op == 4'd1 || op == 4'd6) && lo != 2'd0) ||
           ((op == 4'd2 || op == 4'd3 || op == 4'd7) && lo[0]);
    hv   = 16'((rd >> (16 - 8 * int'(lo))) & 32'hFFFF);
    bv   = 8'((rd >> (24 - 8 * int'(lo))) & 32'hFF);
    expEn = 4'h0; expWd = sd; expLoad = '0;
    if (isSt && !mis) begin
      case (op)
        4'd6: expEn = 4'hF;
        4'd7: begin expEn = (lo == 2'd0) ? 4'hC : 4'h3; expWd = {2{sd[15:0]}}; end
        default: begin expEn = 4'(8 >> lo); expWd = {4{sd[7:0]}}; end
      endcase
    end
    if (isLd && !mis) begin
      case (op)
        4'd1: expLoad = rd;
        4'd2: expLoad = {{16{hv[15]}}, hv};
        4'd3: expLoad = {16'h0, hv};
        4'd4: expLoad = {{24{bv[7]}}, bv};
        default: expLoad = {24'h0, bv};
      endcase
    end
    chk("R1", "memAddr", memAddr, {ea[31:2], 2'b00});
    chk("R8", "misalign", {31'h0, misalign}, {31'h0, mis});
    chk(mis ? "R8" : opTag(op), "memByteEn", {28'h0, memByteEn}, {28'h0, expEn});
    chk(mis ? "R8" : opTag(op), "loadResult", loadResult, expLoad);
    if (isSt && !mis) chk(opTag(op), "memWdata", memWdata, expWd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] offs [8];
    logic [31:0] rds [3];
    logic [31:0] bases [2];
    offs  = '{16'h0000, 16'h0004, 16'hFFFC, 16'h7FFC, 16'h8000, 16'h0001, 16'h0002, 16'h0003};
    rds   = '{32'h1234ABCD, 32'h80FF7F01, 32'h7F80017E};
    bases = '{32'h1000_0000, 32'hFFFF_FFF0};
    repeat (3) @(posedge clk);
    #2;
    // Reset state with the idle code: R9
    chk("R9", "idle memByteEn", {28'h0, memByteEn}, 32'h0);
    chk("R9", "idle loadResult", loadResult, 32'h0);
    chk("R9", "idle misalign", {31'h0, misalign}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int op = 0; op < 16; op++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 4; l++)
          for (int o = 0; o < 8; o++)
            for (int r = 0; r < 3; r++)
              runOne(4'(op), bases[b] + 32'(l), offs[o], 32'hCAFE_9B3C ^ rds[r], rds[r]);
    // Documented lane example: 0x1234ABCD, offset 2 byte signed gives 0xFFFFFFAB (R6)
    runOne(4'd4, 32'h0000_0100, 16'h0002, 32'h0, 32'h1234ABCD);
    chk("R6", "example byte", loadResult, 32'hFFFF_FFAB);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule